// File: doc/BRIEF.md
# Four-Ratio Dual-Band Clock Prescaler

This block divides a fast input clock by one of four ratios: 32, 33, 47 or 48. A small divide-by-2-or-3 core is followed by a chain of divide-by-2 stages. With the default of four stages, the chain adds a fixed factor of 16. A band select picks the low band or the high band. In the low band the core normally divides by 2. In the high band the core's control is inverted, so the core normally divides by 3. A modulus input then decides whether one core period in each output cycle takes the other length. That single exceptional period is what gives 33 (low band) or 47 (high band). The high-band ratios cost only an inverter and a multiplexer on the core's control. No flip-flop is added for them.

The model is single-clock. Instead of a slow clock net it produces a one-cycle boundary pulse at the end of every output cycle. It also brings out the last divide-by-2 stage as a slow square-ish wave. Band select and modulus are sampled at reset and at each output boundary. A change made partway through an output cycle therefore affects only the following cycle. This lets the swallow counter of a pulse-swallow synthesizer drive the modulus input freely.

Top module: `mmp_prescaler`

## Requirements
- R1: While `rst` is high, `out_tick` and `div_out` are 0. The first `out_tick` after reset is released comes in the N-th clock cycle, where N is the ratio selected by the inputs present during reset. This holds for a reset applied in the middle of an output cycle as well.
- R2: With `band_sel`=0 and `mod_in`=1, consecutive `out_tick` pulses are 32 clock cycles apart.
- R3: With `band_sel`=0 and `mod_in`=0, consecutive `out_tick` pulses are 33 clock cycles apart.
- R4: With `band_sel`=1 and `mod_in`=1, consecutive `out_tick` pulses are 48 clock cycles apart.
- R5: With `band_sel`=1 and `mod_in`=0, consecutive `out_tick` pulses are 47 clock cycles apart.
- R6: `out_tick` is high for exactly one clock cycle per output cycle.
- R7: `band_sel` and `mod_in` are sampled only on the clock edge that ends an `out_tick` cycle (and during reset). A change at any other time leaves the ratio of the output cycle in progress unchanged and takes effect in the next one.
- R8: `div_out` is 1 during the `out_tick` cycle and 0 in the cycle right after it.
- R9: The lengthened or shortened core period is the last one before the boundary. So `div_out` is low for 16 cycles and high for 16 (ratio 32), 16 and 17 (33), 24 and 24 (48), or 24 and 23 (47), with the high count including the `out_tick` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high; clears the core and every divide-by-2 stage |
| band_sel | input | 1 | 0: low band (32/33); 1: high band (47/48) |
| mod_in | input | 1 | 1: no exceptional core period (32 or 48); 0: one exceptional period (33 or 47) |
| out_tick | output | 1 | One-cycle pulse in the last cycle of each output cycle |
| div_out | output | 1 | Output of the last divide-by-2 stage |

## Verification
The bench runs each band/modulus pair from reset and measures both the full period and the low/high split of `div_out`. A design that put the exceptional core period at the wrong chain state would still show the right total but fail the split. A design that mixed up the inverting multiplexer would swap 47 and 48, or give 31 instead of 33.

Inputs are changed early in a cycle, late in a cycle, and exactly in the boundary cycle. A design that took the inputs without waiting for the boundary would shorten or stretch the cycle in progress. A design that latched one edge late would delay the new ratio by a whole cycle.

A reset in the middle of a cycle must restart the count cleanly. A design that left any divide-by-2 stage uncleared would produce an early first pulse.

// File: rtl/mmp_pkg.sv
package mmp_pkg;

   typedef enum logic {
      BAND_LO = 1'b0,
      BAND_HI = 1'b1
   } band_e;

   typedef struct packed {
      band_e band;
      logic  mod;
   } mode_t;

   // Core encodings selectable by parameter
   localparam int CORE_BINARY = 0;
   localparam int CORE_ONEHOT = 1;

   // Division ratio of one output cycle for a given chain length and mode
   function automatic int ratio(input int stages, input logic band, input logic mod);
      int base;
      base = 1 << stages;
      if (band == 1'b0)
         return 2 * base + (mod ? 0 : 1);
      else
         return 3 * base - (mod ? 0 : 1);
   endfunction

endpackage

// File: rtl/mmp_core23.sv
module mmp_core23 #(
   parameter int STYLE = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic div2,
   output logic tick
);
   import mmp_pkg::*;

   if (STYLE != CORE_BINARY && STYLE != CORE_ONEHOT) begin : g_bad_style
      $error("mmp_core23: unsupported STYLE %0d", STYLE);
   end

   if (STYLE == CORE_ONEHOT) begin : g_onehot
      logic [2:0] phase;

      assign tick = div2 ? phase[1] : phase[2];

      always_ff @(posedge clk) begin
         if (rst)
            phase <= 3'b001;
         else if (tick)
            phase <= 3'b001;
         else
            phase <= {phase[1:0], 1'b0};
      end
   end else begin : g_binary
      logic [1:0] cnt;

      assign tick = div2 ? (cnt == 2'd1) : (cnt == 2'd2);

      always_ff @(posedge clk) begin
         if (rst)
            cnt <= 2'd0;
         else if (tick)
            cnt <= 2'd0;
         else
            cnt <= cnt + 2'd1;
      end
   end

endmodule

// File: rtl/mmp_div2_stage.sv
module mmp_div2_stage (
   input  logic clk,
   input  logic rst,
   input  logic en_in,
   output logic q,
   output logic en_out
);

   always_ff @(posedge clk) begin
      if (rst)
         q <= 1'b0;
      else if (en_in)
         q <= ~q;
   end

   // Next stage advances when this one falls from 1 to 0
   assign en_out = en_in & q;

endmodule

// File: rtl/mmp_ctrl.sv
module mmp_ctrl (
   input  logic clk,
   input  logic rst,
   input  logic band_sel,
   input  logic mod_in,
   input  logic boundary,
   input  logic at_term,
   output logic div2
);
   import mmp_pkg::*;

   mode_t mode_q;
   logic  mc;

   always_ff @(posedge clk) begin
      if (rst || boundary)
         mode_q <= '{band: band_e'(band_sel), mod: mod_in};
   end

   // NAND of inverted modulus with the chain's terminal state
   assign mc = ~((~mode_q.mod) & at_term);

   // Band multiplexer: straight control in the low band, inverted in the high band
   assign div2 = (mode_q.band == BAND_HI) ? ~mc : mc;

endmodule

// File: rtl/mmp_prescaler.sv
module mmp_prescaler #(
   parameter int STAGES     = 4,
   parameter int TERM_STATE = -1,
   parameter int CORE_STYLE = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic band_sel,
   input  logic mod_in,
   output logic out_tick,
   output logic div_out
);

   localparam int CHAIN_MAX = (1 << STAGES) - 1;
   localparam int TERM      = (TERM_STATE < 0) ? CHAIN_MAX : TERM_STATE;
   localparam logic [STAGES-1:0] TERM_V = STAGES'(TERM);

   if (STAGES < 1 || STAGES > 10) begin : g_bad_stages
      $error("mmp_prescaler: STAGES %0d out of range 1..10", STAGES);
   end
   if (TERM > CHAIN_MAX) begin : g_bad_term
      $error("mmp_prescaler: TERM_STATE %0d exceeds chain range", TERM);
   end

   logic              core_tick;
   logic              core_div2;
   logic [STAGES:0]   carry;
   logic [STAGES-1:0] chain;
   logic              at_term;

   mmp_core23 #(.STYLE(CORE_STYLE)) u_core (
      .clk  (clk),
      .rst  (rst),
      .div2 (core_div2),
      .tick (core_tick)
   );

   assign carry[0] = core_tick;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      mmp_div2_stage u_st (
         .clk    (clk),
         .rst    (rst),
         .en_in  (carry[i]),
         .q      (chain[i]),
         .en_out (carry[i+1])
      );
   end

   assign at_term = (chain == TERM_V);

   mmp_ctrl u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .band_sel (band_sel),
      .mod_in   (mod_in),
      .boundary (carry[STAGES]),
      .at_term  (at_term),
      .div2     (core_div2)
   );

   assign out_tick = carry[STAGES];
   assign div_out  = chain[STAGES-1];

endmodule

// File: rtl/mmp_checker.sv
module mmp_checker #(
   parameter int STAGES = 4
) (
   input logic clk,
   input logic rst,
   input logic band_sel,
   input logic mod_in,
   input logic out_tick,
   input logic div_out
);
   localparam int GW   = STAGES + 3;
   localparam int BASE = 1 << STAGES;

   logic [GW-1:0] gap;
   logic          sel_q;
   logic          mod_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap   <= '0;
         sel_q <= band_sel;
         mod_q <= mod_in;
      end else begin
         gap <= out_tick ? '0 : gap + 1'b1;
         if (out_tick) begin
            sel_q <= band_sel;
            mod_q <= mod_in;
         end
      end
   end

   p_reset_r1: assert property (@(posedge clk) rst |=> (!out_tick && !div_out));

   // Ratios use the mode seen at the last boundary (R7)
   p_lo32_r2: assert property (@(posedge clk) disable iff (rst)
      (out_tick && !sel_q && mod_q) |-> (gap == GW'(2*BASE - 1)));
   p_lo33_r3: assert property (@(posedge clk) disable iff (rst)
      (out_tick && !sel_q && !mod_q) |-> (gap == GW'(2*BASE)));
   p_hi48_r4: assert property (@(posedge clk) disable iff (rst)
      (out_tick && sel_q && mod_q) |-> (gap == GW'(3*BASE - 1)));
   p_hi47_r5: assert property (@(posedge clk) disable iff (rst)
      (out_tick && sel_q && !mod_q) |-> (gap == GW'(3*BASE - 2)));

   p_single_r6: assert property (@(posedge clk) disable iff (rst)
      out_tick |=> !out_tick);

   p_tick_high_r8: assert property (@(posedge clk) disable iff (rst)
      out_tick |-> div_out);
   p_fall_r8: assert property (@(posedge clk) disable iff (rst)
      out_tick |=> !div_out);

endmodule

bind mmp_prescaler mmp_checker #(.STAGES(STAGES)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .band_sel (band_sel),
   .mod_in   (mod_in),
   .out_tick (out_tick),
   .div_out  (div_out)
);

// File: tb/tb_mmp_prescaler.sv
module tb_mmp_prescaler;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic band_sel = 1'b0;
   logic mod_in = 1'b1;
   logic out_tick;
   logic div_out;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mmp_prescaler dut (
      .clk      (clk),
      .rst      (rst),
      .band_sel (band_sel),
      .mod_in   (mod_in),
      .out_tick (out_tick),
      .div_out  (div_out)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset(input bit s, input bit m);
      @(negedge clk);
      band_sel = s;
      mod_in   = m;
      rst      = 1'b1;
      repeat (3) @(negedge clk);
      chk(!out_tick && !div_out, "R1 outputs idle in reset", {out_tick, div_out}, 0);
      rst = 1'b0;
   endtask

   // Called on the negedge where rst was released
   task automatic first_tick(input int n, input string tag);
      int k = 0;
      do begin
         @(negedge clk);
         k++;
      end while (!out_tick && k < 400);
      chk(k == n - 1, tag, k, n - 1);
   endtask

   // Called on an out_tick negedge; returns at the next out_tick negedge
   task automatic period(output int total, output int low, output int high,
                         input int chg_at, input bit ns, input bit nm);
      total = 0;
      low   = 0;
      high  = 0;
      while (total < 1000) begin
         @(negedge clk);
         total++;
         if (total == 1) begin
            chk(!out_tick, "R6 pulse one cycle wide", out_tick, 0);
            chk(!div_out, "R8 div_out low after tick", div_out, 0);
         end
         if (total == chg_at) begin
            band_sel = ns;
            mod_in   = nm;
         end
         if (div_out) high++;
         else         low++;
         if (out_tick) break;
      end
      chk(div_out, "R8 div_out high in tick cycle", div_out, 1);
   endtask

   task automatic test_mode(input bit s, input bit m, input int n, input int lo,
                            input int hi, input string tag);
      int t, l, h;
      do_reset(s, m);
      first_tick(n, {"R1 first tick ", tag});
      for (int i = 0; i < 3; i++) begin
         period(t, l, h, 0, s, m);
         chk(t == n, {tag, " period"}, t, n);
         chk(l == lo, {"R9 low phase ", tag}, l, lo);
         chk(h == hi, {"R9 high phase ", tag}, h, hi);
      end
   endtask

   task automatic test_switch();
      int t, l, h;
      do_reset(1'b0, 1'b1);
      first_tick(32, "R1 first tick before switch");
      period(t, l, h, 5, 1'b1, 1'b0);
      chk(t == 32, "R7 early change keeps current ratio", t, 32);
      period(t, l, h, 30, 1'b1, 1'b1);
      chk(t == 47, "R7 new ratio from next cycle", t, 47);
      period(t, l, h, 1, 1'b0, 1'b0);
      chk(t == 48, "R7 late change applies next cycle", t, 48);
      period(t, l, h, 0, 1'b0, 1'b0);
      chk(t == 33, "R7 change right after boundary", t, 33);
      band_sel = 1'b0;
      mod_in   = 1'b1;
      period(t, l, h, 0, 1'b0, 1'b1);
      chk(t == 32, "R7 change in boundary cycle applies at once", t, 32);
   endtask

   task automatic test_midreset();
      int t, l, h;
      do_reset(1'b1, 1'b1);
      first_tick(48, "R1 first tick before mid reset");
      repeat (20) @(negedge clk);
      band_sel = 1'b0;
      mod_in   = 1'b0;
      rst      = 1'b1;
      @(negedge clk);
      chk(!out_tick && !div_out, "R1 mid-cycle reset clears outputs", {out_tick, div_out}, 0);
      rst = 1'b0;
      first_tick(33, "R1 restart after mid reset");
      period(t, l, h, 0, 1'b0, 1'b0);
      chk(t == 33, "R3 period after mid reset", t, 33);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      test_mode(1'b0, 1'b1, 32, 16, 16, "R2");
      test_mode(1'b0, 1'b0, 33, 16, 17, "R3");
      test_mode(1'b1, 1'b1, 48, 24, 24, "R4");
      test_mode(1'b1, 1'b0, 47, 24, 23, "R5");
      test_switch();
      test_midreset();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         summary();
         $finish;
      end
   end

endmodule